// File: doc/BRIEF.md
# Bus Listener Byte Acceptor

This block is a listen-only endpoint on a parallel instrument bus that uses the three-wire DAV / NRFD / NDAC handshake. It watches the bus passively and takes no part in addressing. Each byte moves through a fixed cycle. The block holds both of its handshake lines asserted. It then releases not-ready-for-data and waits for data-valid. It captures the byte with its attention and end flags, releases not-data-accepted, and waits for data-valid to drop. After that it asserts both lines again.

The block has two phases. In the idle phase every byte is thrown away, except a start byte (0x24) that arrives while attention is asserted. That byte opens a session. In the session phase every byte goes to a downstream consumer over a valid/ready interface, and the end flag travels with it as the last marker. When the consumer takes the last byte, the block goes back to idle. The block does not release not-ready-for-data while a byte is still waiting for the consumer. This lets a slow consumer stall the bus controller.

All bus lines are active low. Inputs arrive as the raw line levels. The two handshake outputs are drive-low enables for an external open-collector driver.

Top module: `gpib_listen_accept`

## Requirements
- R1: While reset is active, both `nrfd_drive` and `ndac_drive` are 1 (lines pulled low) and `out_valid` is 0.
- R2: `nrfd_drive` goes to 0 only while `ndac_drive` is 1. With no byte pending, the block releases NRFD within a few cycles of reset or of finishing the previous byte.
- R3: Once DAV has been seen low through the two-stage synchronizer, the block captures the byte as the inverse of `bus_dio_n`, with ATN and EOI, where a line at level 0 means asserted. It then sets `ndac_drive` to 0 and `nrfd_drive` to 1.
- R4: `ndac_drive` stays at 0 until DAV has returned high. After that, `ndac_drive` and `nrfd_drive` are both 1 before NRFD is released again.
- R5: In the idle phase, a byte opens a session only if it equals 0x24 and ATN was asserted. Any other byte, including 0x24 without ATN or another value with ATN, produces no output, and the block re-arms for the next byte.
- R6: In the session phase, each accepted byte is offered on `out_data`, with `out_last` equal to its captured EOI. `out_valid`, `out_data` and `out_last` stay stable until `out_ready` is 1.
- R7: While `out_valid` is 1, `nrfd_drive` stays at 1.
- R8: Once the consumer takes the byte whose `out_last` is 1, the block returns to idle. A later byte without a new ATN-qualified 0x24 produces no output.
- R9: The start byte that opens a session is never offered downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_dav_n | input | 1 | Data-valid line level, low = asserted |
| bus_atn_n | input | 1 | Attention line level, low = asserted |
| bus_eoi_n | input | 1 | End line level, low = asserted |
| bus_dio_n | input | DW | Data line levels, low = bit set |
| nrfd_drive | output | 1 | 1 pulls not-ready-for-data low |
| ndac_drive | output | 1 | 1 pulls not-data-accepted low |
| out_valid | output | 1 | Byte offered to consumer |
| out_data | output | DW | Offered byte |
| out_last | output | 1 | Offered byte carried EOI |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
The bench sends bytes that look almost like a start byte: 0x24 without attention, and a different value with attention. A design that decodes only one of the two conditions would open a session on one of these bytes and emit output. It holds data-valid low for many cycles after the acceptance. A design that re-asserts not-data-accepted early would break the interlock and could take the same byte twice. It stalls the consumer with the last byte pending. A design without backpressure would release not-ready-for-data and lose bytes, and a design that leaves the session early would drop the output. After the session ends, the bench sends a plain byte. A design that stays in the session would pass that byte downstream.

// File: rtl/gpib_listen_accept.sv
module gpib_listen_accept #(
  parameter int              DW         = 8,
  parameter int              SYNC       = 2,
  parameter logic [DW-1:0]   START_CODE = 8'h24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_dav_n,
  input  logic          bus_atn_n,
  input  logic          bus_eoi_n,
  input  logic [DW-1:0] bus_dio_n,
  output logic          nrfd_drive,
  output logic          ndac_drive,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          out_ready
);

  typedef enum logic [1:0] {S_HOLD, S_ARM, S_ACK, S_OFFER} st_t;

  st_t             st;
  logic [SYNC-1:0] dav_q, atn_q;
  logic            dav_s, atn_s;
  logic [DW-1:0]   byte_q;
  logic            atn_cap, eoi_cap, session;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dav_q <= '0;
      atn_q <= '0;
    end else begin
      dav_q <= {dav_q[SYNC-2:0], ~bus_dav_n};
      atn_q <= {atn_q[SYNC-2:0], ~bus_atn_n};
    end

  assign dav_s = dav_q[SYNC-1];
  assign atn_s = atn_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_HOLD;
      byte_q  <= '0;
      atn_cap <= 1'b0;
      eoi_cap <= 1'b0;
      session <= 1'b0;
    end else begin
      case (st)
        S_HOLD: st <= S_ARM;
        S_ARM:
          if (dav_s) begin
            byte_q  <= ~bus_dio_n;
            atn_cap <= atn_s;
            eoi_cap <= ~bus_eoi_n;
            st      <= S_ACK;
          end
        S_ACK:
          if (!dav_s) begin
            if (session) st <= S_OFFER;
            else begin
              if (atn_cap && byte_q == START_CODE) session <= 1'b1;
              st <= S_HOLD;
            end
          end
        S_OFFER:
          if (out_ready) begin
            if (eoi_cap) session <= 1'b0;
            st <= S_ARM;
          end
        default: st <= S_HOLD;
      endcase
    end

  assign nrfd_drive = (st != S_ARM);
  assign ndac_drive = (st != S_ACK);
  assign out_valid  = (st == S_OFFER);
  assign out_data   = byte_q;
  assign out_last   = eoi_cap;

  always_comb
    if (!rst_n)
      AST_RST_HOLD: assert (nrfd_drive && ndac_drive && !out_valid); // R1

  AST_NRFD_WITH_NDAC: assert property (@(posedge clk) disable iff (!rst_n)
    !nrfd_drive |-> ndac_drive); // R2
  AST_NDAC_AFTER_DAV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ndac_drive) |-> dav_s && nrfd_drive); // R3
  AST_NDAC_UNTIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !ndac_drive && dav_s |=> !ndac_drive); // R4
  AST_REASSERT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ndac_drive) |-> nrfd_drive && !dav_s); // R4
  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R6
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> nrfd_drive); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !session |-> !out_valid); // R5
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !session); // R8

endmodule

// File: tb/tb_gpib_listen_accept.sv
module tb_gpib_listen_accept;
  logic clk = 0, rst_n = 0;
  logic dav_n = 1, atn_n = 1, eoi_n = 1;
  logic [7:0] dio_n = 8'hFF;
  logic nrfd_drive, ndac_drive, out_valid, out_last, out_ready = 1;
  logic [7:0] out_data;
  int total = 0, bad = 0, got_cnt = 0;
  logic [7:0] got_data;
  logic got_last;

  always #5 clk = ~clk;

  gpib_listen_accept dut (
    .clk(clk), .rst_n(rst_n), .bus_dav_n(dav_n), .bus_atn_n(atn_n),
    .bus_eoi_n(eoi_n), .bus_dio_n(dio_n), .nrfd_drive(nrfd_drive),
    .ndac_drive(ndac_drive), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready));

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      got_cnt++;
      got_data = out_data;
      got_last = out_last;
    end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_nrfd_free();
    for (int i = 0; i < 200 && nrfd_drive; i++) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic atn, input logic eoi, input int hold);
    wait_nrfd_free();
    chk(!nrfd_drive && ndac_drive, "R2 armed", {nrfd_drive, ndac_drive}, 2'b01);
    atn_n = ~atn; eoi_n = ~eoi; dio_n = ~d;
    @(negedge clk); @(negedge clk);
    dav_n = 0;
    for (int i = 0; i < 50 && ndac_drive; i++) @(negedge clk);
    chk(!ndac_drive && nrfd_drive, "R3 accept", {nrfd_drive, ndac_drive}, 2'b10);
    for (int i = 0; i < hold; i++) @(negedge clk);
    chk(!ndac_drive, "R4 ndac held while DAV low", ndac_drive, 0);
    dav_n = 1;
    for (int i = 0; i < 50 && !ndac_drive; i++) @(negedge clk);
    chk(ndac_drive && nrfd_drive, "R4 reassert both", {nrfd_drive, ndac_drive}, 2'b11);
    atn_n = 1; eoi_n = 1; dio_n = 8'hFF;
  endtask

  task automatic t_reset();
    #1;
    chk(nrfd_drive && ndac_drive && !out_valid, "R1 reset",
        {nrfd_drive, ndac_drive, out_valid}, 3'b110);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!nrfd_drive && ndac_drive, "R2 release after reset", {nrfd_drive, ndac_drive}, 2'b01);
  endtask

  task automatic t_ignore();
    int c0 = got_cnt;
    send_byte(8'h41, 0, 0, 2);
    send_byte(8'h24, 0, 0, 2);
    send_byte(8'h25, 1, 0, 2);
    repeat (6) @(negedge clk);
    chk(got_cnt == c0, "R5 non-start bytes dropped", got_cnt - c0, 0);
    chk(!nrfd_drive, "R5 re-armed", nrfd_drive, 0);
  endtask

  task automatic t_session();
    int c0 = got_cnt;
    send_byte(8'h24, 1, 0, 2);
    repeat (4) @(negedge clk);
    chk(got_cnt == c0, "R9 start byte not offered", got_cnt - c0, 0);
    send_byte(8'hA5, 0, 0, 2);
    repeat (3) @(negedge clk);
    chk(got_cnt == c0 + 1 && got_data == 8'hA5 && !got_last, "R3 data A5",
        got_data, 8'hA5);
    send_byte(8'h00, 1, 0, 12);
    repeat (3) @(negedge clk);
    chk(got_cnt == c0 + 2 && got_data == 8'h00, "R6 data 00 in session", got_data, 0);
    send_byte(8'hFF, 0, 1, 2);
    repeat (3) @(negedge clk);
    chk(got_cnt == c0 + 3 && got_data == 8'hFF && got_last, "R6 last flag",
        {got_last, got_data}, 9'h1FF);
  endtask

  task automatic t_after_eoi();
    int c0 = got_cnt;
    send_byte(8'h5A, 0, 0, 2);
    repeat (6) @(negedge clk);
    chk(got_cnt == c0, "R8 idle after last", got_cnt - c0, 0);
  endtask

  task automatic t_backpressure();
    int c0;
    logic ok = 1;
    send_byte(8'h24, 1, 0, 2);
    out_ready = 0;
    c0 = got_cnt;
    send_byte(8'h3C, 0, 1, 2);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!out_valid || !nrfd_drive || out_data != 8'h3C || !out_last) ok = 0;
    end
    chk(ok, "R7 stall holds NRFD and offer", {out_valid, nrfd_drive}, 2'b11);
    chk(got_cnt == c0, "R6 no take while not ready", got_cnt - c0, 0);
    out_ready = 1;
    repeat (4) @(negedge clk);
    chk(got_cnt == c0 + 1 && got_data == 8'h3C, "R6 taken after ready", got_data, 8'h3C);
    chk(!nrfd_drive, "R7 NRFD freed after take", nrfd_drive, 0);
    c0 = got_cnt;
    send_byte(8'h24, 0, 0, 2);
    repeat (6) @(negedge clk);
    chk(got_cnt == c0, "R8 stalled last ended session", got_cnt - c0, 0);
  endtask

  initial begin
    t_reset();
    t_ignore();
    t_session();
    t_after_eoi();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule